// File: doc/BRIEF.md
# Configurable Serial Peripheral Bus Master

This block runs one full-duplex word exchange with a single attached slave device over a four-wire synchronous serial link. A one-cycle start request hands it a parallel transmit word together with the clock polarity, clock phase, bit order and a lead-in wait. It pulls the active-low select line low, waits the requested number of system clocks, and then toggles the serial clock for one full word. Each serial clock period moves one bit out and one bit in. When the word is complete, it parks the serial clock at its idle level, releases select and strobes the received word out.

The serial half-period is a build-time parameter counted in system clocks. The word width is also a parameter. Polarity, phase, bit order and the lead-in wait are taken at the moment the start request is accepted and stay fixed for that transfer. A start request that arrives while a transfer is running is dropped.

Top module: `spi_xfer_master`

## Requirements
- R1: While select is high, the serial clock rests at the level given by `cpol` (0 gives low, 1 gives high), and it returns to that level after a transfer.
- R2: A transfer produces exactly 2*WORD_W serial clock transitions. The slave receives `tx_word` and `rx_word` returns the slave's word.
- R3: With `cpha`=0, the first bit is on `mosi` in the cycle after select falls. Later bits change on transitions toward idle, and `miso` is sampled on transitions away from idle.
- R4: With `cpha`=1, `mosi` changes on transitions away from idle, and `miso` is sampled on transitions toward idle.
- R5: With `lsb_first`=1, bit 0 of `tx_word` goes out first and the first bit received lands in bit 0 of `rx_word`. With `lsb_first`=0, bit WORD_W-1 is first in both directions.
- R6: The first serial clock transition comes exactly `lead_cycles`+HALF_DIV system clocks after select falls. A wait of 0 is allowed.
- R7: Successive serial clock transitions are HALF_DIV system clocks apart. Select rises HALF_DIV system clocks after the last transition.
- R8: `busy` is high from the clock after an accepted start until the clock in which select rises. `done` is a one-cycle pulse in that same clock, with `rx_word` valid.
- R9: A start request while `busy` is high is ignored. The running transfer keeps its word and settings, and no second transfer follows.
- R10: During reset, select is high, `busy` and `done` are low, and the serial clock follows `cpol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle transfer request |
| tx_word | input | WORD_W | Word to send |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | Clock phase select |
| lsb_first | input | 1 | 1 sends least significant bit first |
| lead_cycles | input | LEAD_W | System clocks from select low to first clock edge |
| miso | input | 1 | Serial data from slave |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer strobe |
| rx_word | output | WORD_W | Word received |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low slave select |
| mosi | output | 1 | Serial data to slave |

## Verification
The bench runs a behavioural slave that shifts on its own view of the serial clock edges. It drives all four polarity and phase pairings in both bit orders, so a design that samples on the wrong edge returns a word shifted by one bit. A design that fails to present the first bit at select in phase 0 garbles the top bit, and one that reverses in only one direction corrupts words sent least significant bit first. Timing is measured in system clocks at zero lead, a small lead and the largest lead, which exposes a lead counter that is off by one or a half-period divider that miscounts. A second start pulse is injected mid-transfer with a different word, so a design that reloads or restarts shows a wrong received word or an extra select cycle.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEAD  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_TAIL  = 2'd3
  } xfer_state_t;
endpackage

// File: rtl/spi_tick_gen.sv
module spi_tick_gen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_DIV - 1);

  logic [CNT_W-1:0] cnt;

  assign tick = en && (cnt == CNT_LAST);

  always_ff @(posedge clk) begin
    if (rst || !en || tick) cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spi_bit_flip.sv
module spi_bit_flip #(
  parameter int W = 8
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar i = 0; i < W; i++) begin : g_flip
    assign dout[i] = din[W-1-i];
  end
endmodule

// File: rtl/spi_shift_reg.sv
module spi_shift_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift_en,
  input  logic         in_bit,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)           q <= '0;
    else if (load)     q <= load_val;
    else if (shift_en) q <= {q[W-2:0], in_bit};
  end
endmodule

// File: rtl/spi_xfer_master.sv
module spi_xfer_master
  import spi_xfer_pkg::*;
#(
  parameter int WORD_W   = 8,
  parameter int HALF_DIV = 2,
  parameter int LEAD_W   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              lsb_first,
  input  logic [LEAD_W-1:0] lead_cycles,
  input  logic              miso,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] rx_word,
  output logic              sclk,
  output logic              cs_n,
  output logic              mosi
);
  localparam int EDGE_W = $clog2(2 * WORD_W);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(2 * WORD_W - 1);

  xfer_state_t       state;
  logic              cpol_q, cpha_q, lsb_q;
  logic [LEAD_W-1:0] lead_cnt;
  logic [EDGE_W-1:0] edge_cnt;
  logic              rx_hold;
  logic              tick;
  logic              accept;
  logic              trailing;
  logic [WORD_W-1:0] tx_flip, sr, sr_flip, tx_ordered;

  assign accept     = start && (state == ST_IDLE);
  assign trailing   = edge_cnt[0];
  assign tx_ordered = lsb_first ? tx_flip : tx_word;

  spi_tick_gen #(.HALF_DIV(HALF_DIV)) i_tick (
    .clk  (clk),
    .rst  (rst),
    .en   ((state == ST_SHIFT) || (state == ST_TAIL)),
    .tick (tick)
  );

  spi_bit_flip #(.W(WORD_W)) i_flip_tx (.din(tx_word), .dout(tx_flip));
  spi_bit_flip #(.W(WORD_W)) i_flip_rx (.din(sr),      .dout(sr_flip));

  spi_shift_reg #(.W(WORD_W)) i_sr (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .load_val (tx_ordered),
    .shift_en (tick && (state == ST_SHIFT) && trailing),
    .in_bit   (cpha_q ? miso : rx_hold),
    .q        (sr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cs_n     <= 1'b1;
      sclk     <= cpol;
      mosi     <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      rx_word  <= '0;
      lead_cnt <= '0;
      edge_cnt <= '0;
      rx_hold  <= 1'b0;
      cpol_q   <= 1'b0;
      cpha_q   <= 1'b0;
      lsb_q    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          sclk <= cpol;
          if (start) begin
            cpol_q   <= cpol;
            cpha_q   <= cpha;
            lsb_q    <= lsb_first;
            cs_n     <= 1'b0;
            busy     <= 1'b1;
            edge_cnt <= '0;
            mosi     <= tx_ordered[WORD_W-1];
            if (lead_cycles == '0) begin
              state <= ST_SHIFT;
            end else begin
              lead_cnt <= lead_cycles - 1'b1;
              state    <= ST_LEAD;
            end
          end
        end
        ST_LEAD: begin
          if (lead_cnt == '0) state <= ST_SHIFT;
          else                lead_cnt <= lead_cnt - 1'b1;
        end
        ST_SHIFT: begin
          if (tick) begin
            sclk     <= ~sclk;
            edge_cnt <= edge_cnt + 1'b1;
            if (!trailing) begin
              if (cpha_q) mosi    <= sr[WORD_W-1];
              else        rx_hold <= miso;
            end else begin
              if (!cpha_q) mosi <= sr[WORD_W-2];
              if (edge_cnt == LAST_EDGE) state <= ST_TAIL;
            end
          end
        end
        ST_TAIL: begin
          if (tick) begin
            cs_n    <= 1'b1;
            busy    <= 1'b0;
            done    <= 1'b1;
            rx_word <= lsb_q ? sr_flip : sr;
            state   <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_xfer_master_chk.sv
module spi_xfer_master_chk (
  input logic clk,
  input logic rst,
  input logic start,
  input logic cpol,
  input logic busy,
  input logic done,
  input logic sclk,
  input logic cs_n
);
  // R8: select is low for exactly as long as busy is high
  a_r8_busy_selects: assert property (@(posedge clk) disable iff (rst)
    busy |-> !cs_n);
  a_r8_idle_deselects: assert property (@(posedge clk) disable iff (rst)
    !busy |-> cs_n);
  // R8: done lasts one cycle and coincides with select rising
  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r8_done_with_rise: assert property (@(posedge clk) disable iff (rst)
    done |-> $rose(cs_n));
  // R9: an accepted start always leads to busy
  a_r9_start_taken: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
  // R1: serial clock rests at the polarity level while deselected
  a_r1_idle_level: assert property (@(posedge clk) disable iff (rst)
    (cs_n && $past(cs_n)) |-> (sclk == $past(cpol)));
  // R7: the clock does not move when select is released
  a_r7_release_quiet: assert property (@(posedge clk) disable iff (rst)
    done |-> $stable(sclk));
endmodule

bind spi_xfer_master spi_xfer_master_chk i_chk (
  .clk   (clk),
  .rst   (rst),
  .start (start),
  .cpol  (cpol),
  .busy  (busy),
  .done  (done),
  .sclk  (sclk),
  .cs_n  (cs_n)
);

// File: tb/test_spi_xfer_master.sv
module test_spi_xfer_master;
  localparam int W        = 8;
  localparam int HDIV     = 2;
  localparam int LW       = 6;
  localparam int CLK_PER  = 10;
  localparam int WD_LIMIT = 150000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [W-1:0]  tx_word = '0;
  logic          cpol = 1'b1, cpha = 1'b0, lsb_first = 1'b0;
  logic [LW-1:0] lead_cycles = '0;
  logic          miso = 1'b0;
  logic          busy, done, sclk, cs_n, mosi;
  logic [W-1:0]  rx_word;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // slave model configuration, set by the stimulus
  logic [W-1:0] s_word = '0;
  logic s_cpol = 1'b0, s_cpha = 1'b0, s_lsb = 1'b0;

  // slave model state and timing monitor, owned by one process
  logic [W-1:0] s_sr = '0, s_in = '0;
  logic prev_cs = 1'b1, prev_sclk = 1'b0;
  int n_edges = 0, first_gap = -1, bad_int = 0, last_edge = 0, fall_cyc = 0, tail_gap = -1, n_falls = 0;

  spi_xfer_master #(.WORD_W(W), .HALF_DIV(HDIV), .LEAD_W(LW)) i_spi_xfer_master (
    .clk(clk), .rst(rst), .start(start), .tx_word(tx_word), .cpol(cpol), .cpha(cpha),
    .lsb_first(lsb_first), .lead_cycles(lead_cycles), .miso(miso), .busy(busy),
    .done(done), .rx_word(rx_word), .sclk(sclk), .cs_n(cs_n), .mosi(mosi)
  );

  always #(CLK_PER/2) clk = ~clk;

  function automatic logic [W-1:0] rev(input logic [W-1:0] v);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = v[W-1-i];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WD_LIMIT);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  always @(sclk, cs_n) begin
    if (cs_n !== prev_cs) begin
      if (cs_n === 1'b0) begin
        s_sr = s_lsb ? rev(s_word) : s_word;
        s_in = '0;
        miso = s_sr[W-1];
        n_edges = 0; first_gap = -1; bad_int = 0; tail_gap = -1;
        fall_cyc = cyc;
        n_falls++;
      end else if (!rst) begin
        tail_gap = cyc - last_edge;
      end
      prev_cs = cs_n;
    end else if (cs_n === 1'b0 && sclk !== prev_sclk) begin
      if (n_edges == 0) first_gap = cyc - fall_cyc;
      else if (cyc - last_edge != HDIV) bad_int++;
      last_edge = cyc;
      n_edges++;
      if ((sclk !== s_cpol) ^ s_cpha) begin
        s_in = {s_in[W-2:0], mosi};
      end else if (s_cpha) begin
        miso = s_sr[W-1];
        s_sr = s_sr << 1;
      end else begin
        s_sr = s_sr << 1;
        miso = s_sr[W-1];
      end
    end
    prev_sclk = sclk;
  end

  task automatic run_xfer(input logic [W-1:0] tx, input logic [W-1:0] sw, input bit pol,
                          input bit pha, input bit lsb, input int lead, input bit poke);
    logic [W-1:0] got;
    logic first_bit;
    int waited;
    int falls_before;
    @(negedge clk);
    cpol = pol; cpha = pha; lsb_first = lsb; lead_cycles = LW'(lead); tx_word = tx;
    s_word = sw; s_cpol = pol; s_cpha = pha; s_lsb = lsb;
    @(negedge clk);
    chk(sclk == pol && cs_n, "R1 idle level before transfer", {30'd0, cs_n, sclk}, {31'd1, pol});
    falls_before = n_falls;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!cs_n && busy, "R8 busy and select after start", {30'd0, busy, cs_n}, 32'd2);
    first_bit = lsb ? tx[0] : tx[W-1];
    if (!pha) chk(mosi == first_bit, "R3 first bit at select", mosi, first_bit);
    if (poke) begin
      repeat (lead + 3 * HDIV) @(negedge clk);
      tx_word = ~tx; lsb_first = ~lsb; cpha = ~pha;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    waited = 0;
    while (!done && waited < 4000) begin
      @(negedge clk);
      waited++;
    end
    chk(done, "R8 done pulse seen", done, 1);
    chk(cs_n && !busy, "R8 select released with done", {30'd0, busy, cs_n}, 32'd1);
    if (pha) chk(rx_word == sw, "R4 master received word", rx_word, sw);
    else     chk(rx_word == sw, "R3 master received word", rx_word, sw);
    got = lsb ? rev(s_in) : s_in;
    chk(got == tx, "R2 slave received word", got, tx);
    if (lsb) chk(rx_word == sw && got == tx, "R5 lsb first order", {rx_word, got}, {sw, tx});
    chk(n_edges == 2 * W, "R2 clock transition count", n_edges, 2 * W);
    chk(first_gap == lead + HDIV, "R6 select to first edge", first_gap, lead + HDIV);
    chk(bad_int == 0, "R7 half period spacing", bad_int, 0);
    chk(tail_gap == HDIV, "R7 last edge to release", tail_gap, HDIV);
    chk(sclk == pol, "R1 idle level after transfer", sclk, pol);
    @(negedge clk);
    chk(!done, "R8 done lasts one cycle", done, 0);
    if (poke) begin
      repeat (4) @(negedge clk);
      chk(cs_n && !busy && (n_falls - falls_before == 1), "R9 start while busy ignored",
          n_falls - falls_before, 1);
    end
  endtask

  initial begin
    void'($urandom(32'h1A2B3C4D));
    repeat (3) @(negedge clk);
    chk(cs_n && !busy && !done && sclk == 1'b1, "R10 reset state",
        {28'd0, sclk, done, busy, cs_n}, 32'h9);
    cpol = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(sclk == 1'b0 && cs_n, "R10 clock follows polarity in reset", sclk, 0);
    rst = 1'b0;
    @(negedge clk);

    run_xfer(8'hA5, 8'h3C, 1'b0, 1'b0, 1'b0, 2, 1'b0);
    run_xfer(8'h81, 8'h7E, 1'b0, 1'b1, 1'b0, 0, 1'b0);
    run_xfer(8'hF0, 8'h0F, 1'b1, 1'b0, 1'b0, 1, 1'b0);
    run_xfer(8'h6B, 8'hD2, 1'b1, 1'b1, 1'b0, 5, 1'b0);
    run_xfer(8'h01, 8'h80, 1'b0, 1'b0, 1'b1, 3, 1'b0);
    run_xfer(8'hC4, 8'h29, 1'b1, 1'b1, 1'b1, 63, 1'b0);
    run_xfer(8'h5A, 8'hE7, 1'b0, 1'b1, 1'b0, 4, 1'b1);

    for (int n = 0; n < 16; n++) begin
      run_xfer(W'($urandom), W'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
               int'($urandom % 8), 1'b0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule